// File: doc/BRIEF.md
# Seven-Pin Bidirectional GPIO Port

This block is a seven-pin general-purpose I/O port behind a small register bus. It has three registers. A write-only direction register decides, pin by pin, whether the pin drives or listens. A read/write output register holds the level each driving pin puts out. A read-only status register returns the synchronized levels seen on the pins. The pin side provides a per-pin output value, a per-pin tri-state enable, and a per-pin input.

There are two reset classes. The asynchronous power-on reset `rst_ni` and the level-sensitive hardware-standby clear `hw_stby_i` zero both stored registers. The hold input `hold_i` stands for a manual reset or software standby. It freezes the registers without clearing them, so the pins keep their configured state while the rest of the system recovers.

A bus access selects one of four word addresses: 0 direction, 1 output data, 2 pin status, 3 unused. Writes commit on the clock edge. Reads are combinational.

Top module: `gpio_port7`

## Requirements
- R1: Bit 7 of every register ignores writes, and every read returns 1 in bit 7.
- R2: A write to address 0 sets `pin_oe_o[i]` to the written bit i on the next clock edge. A value of 1 means the pin drives (output); 0 means the pin is released (input).
- R3: A read of address 0, the direction register, returns 8'hFF whatever it holds. A read of address 3 also returns 8'hFF.
- R4: A write to address 1 stores bits 6:0, which appear on `pin_o` from the next clock edge. A read of address 1 returns {1'b1, stored bits}.
- R5: `rst_ni` low clears the direction and data registers to zero asynchronously. `hw_stby_i` high clears them on the next clock edge.
- R6: While `hold_i` is high, writes are ignored and the direction and data registers keep their contents.
- R7: A read of address 2 returns {1'b1, pin levels}. Each level is `pin_i` as sampled two clock edges earlier through a two-flop synchronizer.
- R8: Read data follows `rd_i` and `addr_i` in the same cycle. `rdata_o` is 8'h00 while `rd_i` is low.
- R9: `hw_stby_i` takes precedence over both `hold_i` and a concurrent write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| hw_stby_i | input | 1 | Hardware standby, synchronous clear |
| hold_i | input | 1 | Manual reset / software standby, freezes registers |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pin_i | input | 7 | Pin input levels |
| pin_o | output | 7 | Pin output levels |
| pin_oe_o | output | 7 | Pin output enables |

## Verification
Register writes show at the pins one edge after the strobe. The bench drives every strobe on a falling edge and samples at the following falling edge. Read data is combinational, so reads are checked in the same half-cycle as the strobe. Pin levels need two rising edges before the status read reflects them. The bench therefore checks the old value after one edge and the new value after two. A hardware-standby clear takes effect after one edge, and a held write is checked after several edges to confirm nothing moved.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned PINS   = 7;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 2'd0,
    A_DATA = 2'd1,
    A_PIN  = 2'd2,
    A_NONE = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic         we_dir_i,
  input  logic         we_dat_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] dat_o
);
  logic [W-1:0] dir_q, dat_q;

  // clear beats hold beats write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (clr_i) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (!hold_i) begin
      if (we_dir_i) dir_q <= wdata_i;
      if (we_dat_i) dat_q <= wdata_i;
    end
  end

  assign dir_o = dir_q;
  assign dat_o = dat_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sr_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);
  for (genvar b = 0; b < W; b++) begin : g_pad
    assign pin_oe_o[b] = dir_i[b];
    assign pin_o[b]    = dat_i[b];
  end
endmodule

// File: rtl/gpio_port7.sv
module gpio_port7
  import gpio_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_stby_i,
  input  logic              hold_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe_o
);
  localparam int unsigned PAD = REG_W - PINS;

  logic [PINS-1:0] dir, dat, pin_s;
  logic            we_dir, we_dat;

  assign we_dir = wr_i && (addr_i == A_DIR);
  assign we_dat = wr_i && (addr_i == A_DATA);

  gpio_reg_bank #(.W(PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hw_stby_i),
    .hold_i  (hold_i),
    .we_dir_i(we_dir),
    .we_dat_i(we_dat),
    .wdata_i (wdata_i[PINS-1:0]),
    .dir_o   (dir),
    .dat_o   (dat)
  );

  gpio_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  gpio_pad_ctrl #(.W(PINS)) u_pad (
    .dir_i   (dir),
    .dat_i   (dat),
    .pin_o   (pin_o),
    .pin_oe_o(pin_oe_o)
  );

  // undefined locations and reserved bits read as ones
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_DATA:  rdata_o = {{PAD{1'b1}}, dat};
        A_PIN:   rdata_o = {{PAD{1'b1}}, pin_s};
        default: rdata_o = '1;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port7_chk.sv
module gpio_port7_chk
  import gpio_port_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_stby_i,
  input logic              hold_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [PINS-1:0]   pin_i,
  input logic [PINS-1:0]   pin_o,
  input logic [PINS-1:0]   pin_oe_o
);
  AST_RSVD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> rdata_o[REG_W-1]); // R1
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DIR && !hold_i && !hw_stby_i) |=> pin_oe_o == $past(wdata_i[PINS-1:0])); // R2
  AST_DIR_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_DIR) |-> rdata_o == '1); // R3
  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DATA && !hold_i && !hw_stby_i) |=> pin_o == $past(wdata_i[PINS-1:0])); // R4
  AST_STBY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (pin_oe_o == '0 && pin_o == '0)); // R9
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !hw_stby_i) |=> ($stable(pin_oe_o) && $stable(pin_o))); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0); // R8
endmodule

bind gpio_port7 gpio_port7_chk u_chk (.*);

// File: tb/gpio_port7_test.sv
module gpio_port7_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_stby_i = 1'b0;
  logic       hold_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [6:0] pin_i = '0;
  logic [6:0] pin_o;
  logic [6:0] pin_oe_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  gpio_port7 uut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // strobe on a falling edge, released at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    rd_i = 1'b0;
    #1;
  endtask

  logic [7:0] r;

  initial begin
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 reset oe", {1'b0, pin_oe_o}, 8'h00);
    chk("R5 reset out", {1'b0, pin_o}, 8'h00);
    chk("R8 idle rdata", rdata_o, 8'h00);
    rd(2'd1, r); chk("R5 reset data read", r, 8'h80);

    for (int v = 0; v < 256; v++) begin
      wr(2'd0, 8'(v));
      chk("R2 dir to oe", {1'b0, pin_oe_o}, {1'b0, 7'(v)});
      rd(2'd0, r); chk("R3 dir read ones", r, 8'hFF);
    end
    rd(2'd3, r); chk("R3 unused addr", r, 8'hFF);

    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v));
      chk("R4 data to pin", {1'b0, pin_o}, {1'b0, 7'(v)});
      rd(2'd1, r); chk("R1 R4 data read", r, {1'b1, 7'(v)});
    end

    for (int v = 0; v < 128; v += 9) begin
      @(negedge clk_i); pin_i = 7'(v);
      rd(2'd2, r); chk("R7 no change at 0 edges", r, {1'b1, 7'(v == 0 ? 0 : v - 9)});
      @(negedge clk_i);
      rd(2'd2, r); chk("R7 no change at 1 edge", r, {1'b1, 7'(v == 0 ? 0 : v - 9)});
      @(negedge clk_i);
      rd(2'd2, r); chk("R7 pin after 2 edges", r, {1'b1, 7'(v)});
    end

    wr(2'd0, 8'h55); wr(2'd1, 8'h2A);
    @(negedge clk_i); hold_i = 1'b1;
    wr(2'd0, 8'h0F); wr(2'd1, 8'h71);
    repeat (3) @(negedge clk_i);
    chk("R6 hold dir", {1'b0, pin_oe_o}, 8'h55);
    chk("R6 hold data", {1'b0, pin_o}, 8'h2A);
    rd(2'd1, r); chk("R6 hold data read", r, 8'hAA);

    hw_stby_i = 1'b1;
    @(negedge clk_i);
    chk("R9 stby over hold oe", {1'b0, pin_oe_o}, 8'h00);
    chk("R9 stby over hold out", {1'b0, pin_o}, 8'h00);
    hold_i = 1'b0;
    wr(2'd1, 8'h7F);
    chk("R9 stby over write", {1'b0, pin_o}, 8'h00);
    hw_stby_i = 1'b0;
    wr(2'd1, 8'h3C); wr(2'd0, 8'h7E);
    chk("R5 writes after stby", {1'b0, pin_o}, 8'h3C);

    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R5 async reset oe", {1'b0, pin_oe_o}, 8'h00);
    chk("R5 async reset out", {1'b0, pin_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule